// File: doc/BRIEF.md
# Entropy Bit Sampling Controller

This block gathers raw bits from an external entropy source and presents them to software as a bank of readable 32-bit words. Software first programs how many clocks separate two captured bits. It then writes the control register to turn the generator on, pick an oscillator speed code and choose how many bits to collect. Setting the start flag in the same write begins a run.

During a run the block captures one entropy bit at the end of each sample period and places it at the next free bit position of the output bank. When the requested number of bits has been gathered, hardware drops the start flag, so software can poll for completion. It then reads the output words. The oscillator speed code is driven straight out to the entropy source.

Register access uses a simple valid/ready request port. The port is always ready, and read data returns on the cycle after the request.

Top module: `trng_sampler`

## Requirements
- R1: The control register sits at offset 0x400 with bit 0 = START, bit 1 = ENABLE, bits 3:2 = speed code and bits 5:4 = length code. A write changes control bit i (i = 0..5) only when write-data bit i+16 is 1. The upper half is never stored and reads back as 0, and bits 5:1 change only through such writes.
- R2: Output `osc_speed` always equals control bits 3:2.
- R3: A write that sets START while ENABLE is 1 begins a run. START reads 1 while the run lasts and is cleared by hardware once 64*(code+1) bits have been captured (code 0 = 64, 1 = 128, 2 = 192, 3 = 256 bits).
- R4: The sample-period register is at offset 0x404 and holds P. Counting the register write edge that started the run as edge 0, bit j of a run is the entropy input seen at rising edge P*(j+1). A value of 0 behaves as 1.
- R5: Captured bit k lands in output word k/32, bit k%32. The output words sit at offsets 0x410 + 4*w for w = 0..7. A run clears all eight words when it starts, so words beyond the selected length read 0.
- R6: Setting START while ENABLE is (or becomes) 0 starts nothing, and START stays 0.
- R7: Setting START again while a run is active has no effect on the run's timing or data.
- R8: Writing START = 0 or ENABLE = 0 under the mask stops a run at once. A full-mask write of all zero bits stops the generator, and it stays stopped.
- R9: `bus_ready` is always 1. An accepted read returns `rsp_valid` = 1 with its data exactly one cycle later, and `rsp_valid` is 0 otherwise. Unmapped offsets read 0 and ignore writes.
- R10: After reset the control and period registers and all output words read 0, `osc_speed` is 0 and no run is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Register request valid |
| bus_ready | output | 1 | Request accepted (constant 1) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| entropy_bit | input | 1 | Raw entropy bit from the external source |
| osc_speed | output | 2 | Oscillator speed code to the entropy source |

## Verification
Every combination of the four length codes and the sample periods 0, 1, 2 and 3 is run. The entropy input is a hash of the absolute edge number, so a bit taken one edge early or late, or placed at the wrong position, yields a different word. The period-0 and period-1 runs must match, which separates the zero-as-one rule from an off-by-one counter. The longer lengths show both the completion point and the zeroing of unused words. Further patterns are masked and unmasked control writes, a start without enable, a repeated start mid-run, an all-zero stop, and accesses to an unmapped offset.

// File: rtl/trng_pkg.sv
package trng_pkg;
  localparam int ADDR_W   = 12;
  localparam int MASK_LSB = 16;

  localparam logic [ADDR_W-1:0] OFF_CTL = 12'h400;
  localparam logic [ADDR_W-1:0] OFF_PER = 12'h404;
  localparam logic [ADDR_W-1:0] OFF_OUT = 12'h410;

  typedef struct packed {
    logic [1:0] len;
    logic [1:0] speed;
    logic       enable;
    logic       start;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/trng_tick.sv
module trng_tick #(
  parameter int PERIOD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [PERIOD_W-1:0] period,
  output logic                sample
);
  logic [PERIOD_W-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim    = (period == '0) ? '0 : period - PERIOD_W'(1);
    sample = run && (cnt_q == lim);
    if (!run || sample) cnt_d = '0;
    else                cnt_d = cnt_q + PERIOD_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_SAMPLE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    sample |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/trng_collect.sv
module trng_collect #(
  parameter int WORDS  = 8,
  parameter int WORD_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic [1:0]              len,
  input  logic                    sample,
  input  logic                    bit_in,
  output logic                    done,
  output logic [WORDS*WORD_W-1:0] data
);
  localparam int TOTAL = WORDS * WORD_W;
  localparam int BLK   = TOTAL / 4;
  localparam int IDX_W = $clog2(TOTAL + 1);

  logic [TOTAL-1:0] data_q, data_d;
  logic [IDX_W-1:0] idx_q, idx_d, target;
  logic [1:0]       len_q, len_d;

  always_comb begin
    target = (IDX_W'(len_q) + IDX_W'(1)) * IDX_W'(BLK);
    done   = sample && (idx_q == target - IDX_W'(1));
    data_d = data_q;
    idx_d  = idx_q;
    len_d  = len_q;
    if (clear) begin
      data_d = '0;
      idx_d  = '0;
      len_d  = len;
    end else if (sample) begin
      data_d[idx_q] = bit_in;
      idx_d         = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      idx_q  <= '0;
      len_q  <= '0;
    end else if (clear || sample) begin
      data_q <= data_d;
      idx_q  <= idx_d;
      len_q  <= len_d;
    end
  end

  assign data = data_q;

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sample |-> (idx_q < target)); // R3
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (data_q == '0)); // R5
endmodule

// File: rtl/trng_sampler.sv
module trng_sampler #(
  parameter int WORDS    = 8,
  parameter int WORD_W   = 32,
  parameter int PERIOD_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_valid,
  output logic                       bus_ready,
  input  logic                       bus_write,
  input  logic [trng_pkg::ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0]          bus_wdata,
  output logic                       rsp_valid,
  output logic [WORD_W-1:0]          rsp_rdata,
  input  logic                       entropy_bit,
  output logic [1:0]                 osc_speed
);
  import trng_pkg::*;

  localparam int SEL_W = $clog2(WORDS);

  logic [1:0] rs_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  ctl_t                 ctl_q, ctl_d;
  logic [CTL_W-1:0]     wbits;
  logic [PERIOD_W-1:0]  period_q;
  logic                 ctl_wr, per_wr, rd, launch, sample, coll_done;
  logic [WORDS*WORD_W-1:0] coll_data;
  logic [WORD_W-1:0]    words [WORDS];
  logic [ADDR_W-1:0]    off;
  logic                 in_out;
  logic [WORD_W-1:0]    rdata_d, rdata_q;
  logic                 rvalid_q;

  assign bus_ready = 1'b1;
  assign ctl_wr    = bus_valid && bus_write && (bus_addr == OFF_CTL);
  assign per_wr    = bus_valid && bus_write && (bus_addr == OFF_PER);
  assign rd        = bus_valid && !bus_write;

  always_comb begin
    wbits = ctl_q;
    if (ctl_wr) begin
      for (int i = 0; i < CTL_W; i++) begin
        if (bus_wdata[MASK_LSB+i]) wbits[i] = bus_wdata[i];
      end
    end
    ctl_d       = ctl_t'(wbits);
    ctl_d.start = ctl_q.start && !coll_done;
    if (ctl_wr && bus_wdata[MASK_LSB]) begin
      if (!bus_wdata[0])     ctl_d.start = 1'b0;
      else if (!ctl_q.start) ctl_d.start = 1'b1;
    end
    if (!ctl_d.enable) ctl_d.start = 1'b0;
  end

  assign launch = !ctl_q.start && ctl_d.start;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else         ctl_q <= ctl_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     period_q <= '0;
    else if (per_wr) period_q <= bus_wdata[PERIOD_W-1:0];
  end

  trng_tick #(.PERIOD_W(PERIOD_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_ni),
    .run    (ctl_q.start),
    .period (period_q),
    .sample (sample)
  );

  trng_collect #(.WORDS(WORDS), .WORD_W(WORD_W)) u_collect (
    .clk    (clk),
    .rst_n  (rst_ni),
    .clear  (launch),
    .len    (ctl_d.len),
    .sample (sample),
    .bit_in (entropy_bit),
    .done   (coll_done),
    .data   (coll_data)
  );

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    assign words[g] = coll_data[g*WORD_W +: WORD_W];
  end

  assign off    = bus_addr - OFF_OUT;
  assign in_out = (bus_addr >= OFF_OUT) && (off < ADDR_W'(4*WORDS)) &&
                  (off[1:0] == 2'b00);

  always_comb begin
    rdata_d = '0;
    if (bus_addr == OFF_CTL)      rdata_d = WORD_W'(ctl_q);
    else if (bus_addr == OFF_PER) rdata_d = WORD_W'(period_q);
    else if (in_out)              rdata_d = words[off[2 +: SEL_W]];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rvalid_q <= 1'b0;
    else         rvalid_q <= rd;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd) rdata_q <= rdata_d;
  end

  assign rsp_valid = rvalid_q;
  assign rsp_rdata = rdata_q;
  assign osc_speed = ctl_q.speed;

  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_ni)
    ctl_q.start |-> ctl_q.enable); // R6
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_ni)
    coll_done |=> !ctl_q.start); // R3
  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !ctl_wr |=> $stable(ctl_q[CTL_W-1:1])); // R1
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_valid |-> $past(rd)); // R9
endmodule

// File: tb/trng_sampler_bench.sv
module trng_sampler_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic        bus_ready, rsp_valid;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, rsp_rdata;
  logic        entropy_bit = 1'b0;
  logic [1:0]  osc_speed;

  int unsigned cyc = 0;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  trng_sampler u_trng_sampler (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .entropy_bit(entropy_bit), .osc_speed(osc_speed)
  );

  function automatic logic hash(input int unsigned n);
    logic [31:0] m;
    m = n * 32'h9E3779B1;
    return m[13] ^ m[27] ^ m[5];
  endfunction

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) entropy_bit <= hash(cyc + 1);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic v);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    d = rsp_rdata; v = rsp_valid;
    bus_valid = 0;
  endtask

  task automatic run_case(input int len, input int p, input bit restart);
    logic [31:0] d, expw;
    logic v;
    int unsigned c0, peff, bits;
    int spd;
    spd  = (len + p) % 4;
    peff = (p == 0) ? 1 : p;
    bits = 64 * (len + 1);
    wr(12'h404, p);
    wr(12'h400, 32'h003F_0000 | (len << 4) | (spd << 2) | 3);
    c0 = cyc;
    rd(12'h400, d, v);
    chk("R3 start high in run", d[0], 1'b1);
    chk("R2 osc_speed", osc_speed, spd);
    if (restart) begin
      repeat (20) @(negedge clk);
      wr(12'h400, 32'h0001_0001);
    end
    while (cyc < c0 + peff * bits + 1) @(negedge clk);
    rd(12'h400, d, v);
    chk("R3 start cleared at end", d, (len << 4) | (spd << 2) | 2);
    for (int w = 0; w < 8; w++) begin
      expw = '0;
      for (int b = 0; b < 32; b++) begin
        if (32 * w + b < bits) expw[b] = hash(c0 + peff * (32 * w + b + 1));
      end
      rd(12'h410 + 4 * w, d, v);
      chk(restart ? "R7 data after restart" : "R4 R5 output word", d, expw);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R10 reset state
    rd(12'h400, d, v); chk("R10 ctl reset", d, 0);
    rd(12'h404, d, v); chk("R10 period reset", d, 0);
    rd(12'h41C, d, v); chk("R10 word reset", d, 0);
    chk("R10 osc_speed reset", osc_speed, 0);
    // R9 bus behaviour
    chk("R9 ready", bus_ready, 1);
    chk("R9 rsp_valid on read", v, 1);
    @(negedge clk);
    chk("R9 rsp_valid idle", rsp_valid, 0);
    wr(12'h408, 32'hFFFF_FFFF);
    rd(12'h408, d, v); chk("R9 unmapped reads zero", d, 0);
    rd(12'h400, d, v); chk("R9 unmapped write ignored", d, 0);
    // R6 start without enable
    wr(12'h400, 32'h0001_0001);
    rd(12'h400, d, v); chk("R6 start without enable", d, 0);
    // R1 masked writes
    wr(12'h400, 32'h000E_000A);
    rd(12'h400, d, v); chk("R1 masked write", d, 32'h0A);
    chk("R2 osc_speed follows", osc_speed, 2);
    wr(12'h400, 32'h0000_0035);
    rd(12'h400, d, v); chk("R1 zero mask ignored", d, 32'h0A);
    wr(12'h400, 32'h0008_0000);
    rd(12'h400, d, v); chk("R1 single bit mask", d, 32'h02);
    wr(12'h404, 32'h0000_1234);
    rd(12'h404, d, v); chk("R4 period readback", d, 32'h1234);
    // R3 R4 R5 sweep
    for (int l = 0; l < 4; l++)
      for (int p = 0; p < 4; p++)
        run_case(l, p, 1'b0);
    run_case(1, 2, 1'b1);
    // R8 stop
    wr(12'h404, 3);
    wr(12'h400, 32'h003F_0033);
    repeat (10) @(negedge clk);
    wr(12'h400, 32'h003F_0000);
    rd(12'h400, d, v); chk("R8 stop clears ctl", d, 0);
    repeat (800) @(negedge clk);
    rd(12'h400, d, v); chk("R8 stays stopped", d, 0);
    wr(12'h400, 32'h003F_0033);
    repeat (10) @(negedge clk);
    wr(12'h400, 32'h0002_0000);
    rd(12'h400, d, v); chk("R8 disable stops run", d, 32'h30);
    summary();
  end
endmodule